// File: doc/BRIEF.md
# Radix-4 Booth Sequential Multiplier

This block multiplies two signed two's-complement operands over several clock cycles and returns the double-width product as a high word and a low word. A one-cycle start strobe captures both operands. The block then clears the upper accumulator and loads the multiplier into the low register. On each busy cycle it retires two multiplier bits. It recodes them with the bit saved from the previous step, adds zero or adds or subtracts one or two times the sign-extended multiplicand on an adder two bits wider than the operand, and shifts the high/low pair right by two places. The two bits that drop out of the adder enter the top of the low word.

The sequence has a fixed length, so a caller can either count cycles or wait for the done strobe. The high and low outputs come straight from the working registers. They change while the multiply is in progress and stay frozen from the done strobe until the next accepted start.

Top module: `booth4_mul`

## Requirements
- R1: When `done` is high, `{hi, lo}` equals the signed product of the `mcand` and `mplier` values that were present when the start was accepted, as a 64-bit two's-complement value.
- R2: A start accepted at a clock edge raises `busy`. `busy` stays high for exactly 16 edges after that edge. At the 16th edge `busy` falls and `done` rises.
- R3: `done` is high for exactly one cycle per multiply, and `busy` and `done` are never high together.
- R4: From the `done` strobe until the next accepted start, `hi` and `lo` keep their values.
- R5: A `start` pulse while `busy` is high is ignored. The running multiply keeps its operands, its length and its result.
- R6: After synchronous reset, `busy`, `done`, `hi` and `lo` are all 0.
- R7: Each step recodes the window {low bit 1, low bit 0, saved bit}. Window 000 and 111 add nothing. Windows 001 and 010 add the multiplicand. Window 011 adds twice the multiplicand. Window 100 subtracts twice the multiplicand. Windows 101 and 110 subtract the multiplicand. Multipliers 0x55555555, 0xAAAAAAAA, 0xFFFFFFFF, 0x33333333, 0x66666666 and 0x0000000C together reach all eight windows and must produce correct products.
- R8: Edge operands give exact results. The most negative value squared gives 0x4000000000000000. The most negative value times -1 gives 0x0000000080000000. Any value times 0 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, accepted only while idle |
| mcand | input | 32 | Signed multiplicand |
| mplier | input | 32 | Signed multiplier |
| busy | output | 1 | Multiply in progress |
| done | output | 1 | One-cycle strobe, product valid |
| hi | output | 32 | Upper half of the product |
| lo | output | 32 | Lower half of the product |

## Verification
The bench uses the default operand width of 32 bits, which gives 16 iterations and a 34-bit adder. At this width the full-range corners can be reached: the most negative operand, the overflow of the x2 term into the two extension bits, and sign propagation through all 64 product bits. The directed multipliers are chosen so that every recoding window appears. Random operand pairs cover mixed signs, and a start strobe injected mid-run checks that the running multiply is not disturbed.

// File: rtl/booth4_pkg.sv
package booth4_pkg;

  typedef enum logic [1:0] {
    PP_ZERO = 2'd0,
    PP_X1   = 2'd1,
    PP_X2   = 2'd2
  } pp_mag_t;

  typedef struct packed {
    logic    neg;
    pp_mag_t mag;
  } pp_sel_t;

endpackage

// File: rtl/booth4_recoder.sv
module booth4_recoder
  import booth4_pkg::*;
(
  input  logic [2:0] win,
  output pp_sel_t    sel
);

  always_comb begin
    sel.neg = 1'b0;
    sel.mag = PP_ZERO;
    unique case (win)
      3'b000, 3'b111: begin sel.neg = 1'b0; sel.mag = PP_ZERO; end
      3'b001, 3'b010: begin sel.neg = 1'b0; sel.mag = PP_X1;   end
      3'b011:         begin sel.neg = 1'b0; sel.mag = PP_X2;   end
      3'b100:         begin sel.neg = 1'b1; sel.mag = PP_X2;   end
      default:        begin sel.neg = 1'b1; sel.mag = PP_X1;   end
    endcase
  end

endmodule

// File: rtl/booth4_addsub.sv
module booth4_addsub
  import booth4_pkg::*;
#(
  parameter int ADD_W = 34
) (
  input  logic [ADD_W-1:0] acc,
  input  logic [ADD_W-1:0] mc,
  input  pp_sel_t          sel,
  output logic [ADD_W-1:0] sum
);

  logic [ADD_W-1:0] opnd;
  logic [ADD_W-1:0] opnd_inv;

  always_comb begin
    unique case (sel.mag)
      PP_X1:   opnd = mc;
      PP_X2:   opnd = {mc[ADD_W-2:0], 1'b0};
      default: opnd = '0;
    endcase
  end

  assign opnd_inv = sel.neg ? ~opnd : opnd;
  assign sum      = acc + opnd_inv + {{(ADD_W-1){1'b0}}, sel.neg};

endmodule

// File: rtl/booth4_seq.sv
module booth4_seq #(
  parameter int ITERS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic busy,
  output logic done
);

  localparam int CNT_W = $clog2(ITERS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ITERS - 1);

  logic [CNT_W-1:0] cnt;

  assign load = start && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy) begin
        if (cnt == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/booth4_mul.sv
module booth4_mul
  import booth4_pkg::*;
#(
  parameter int OP_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [OP_W-1:0] mcand,
  input  logic [OP_W-1:0] mplier,
  output logic            busy,
  output logic            done,
  output logic [OP_W-1:0] hi,
  output logic [OP_W-1:0] lo
);

  localparam int ADD_W = OP_W + 2;
  localparam int ITERS = OP_W / 2;

  logic             load;
  logic [OP_W-1:0]  mc_q;
  logic             prev_q;
  logic [ADD_W-1:0] acc_ext;
  logic [ADD_W-1:0] mc_ext;
  logic [ADD_W-1:0] sum;
  pp_sel_t          sel;

  booth4_seq #(.ITERS(ITERS)) u_seq (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .load  (load),
    .busy  (busy),
    .done  (done)
  );

  booth4_recoder u_rec (
    .win (Ilo_win()),
    .sel (sel)
  );

  function automatic logic [2:0] Ilo_win();
    return {lo[1], lo[0], prev_q};
  endfunction

  assign acc_ext = {{2{hi[OP_W-1]}}, hi};
  assign mc_ext  = {{2{mc_q[OP_W-1]}}, mc_q};

  booth4_addsub #(.ADD_W(ADD_W)) u_add (
    .acc (acc_ext),
    .mc  (mc_ext),
    .sel (sel),
    .sum (sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hi     <= '0;
      lo     <= '0;
      mc_q   <= '0;
      prev_q <= 1'b0;
    end else if (load) begin
      hi     <= '0;
      lo     <= mplier;
      mc_q   <= mcand;
      prev_q <= 1'b0;
    end else if (busy) begin
      hi     <= sum[ADD_W-1:2];
      lo     <= {sum[1:0], lo[OP_W-1:2]};
      prev_q <= lo[1];
    end
  end

endmodule

// File: rtl/booth4_mul_chk.sv
module booth4_mul_chk #(
  parameter int OP_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic [OP_W-1:0] mcand,
  input logic [OP_W-1:0] mplier,
  input logic            busy,
  input logic            done,
  input logic [OP_W-1:0] hi,
  input logic [OP_W-1:0] lo
);

  localparam int ITERS = OP_W / 2;
  localparam int CW    = $clog2(ITERS + 2);

  logic [CW-1:0]       edges;
  logic [OP_W-1:0]     a_q;
  logic [OP_W-1:0]     b_q;
  logic signed [2*OP_W-1:0] want;

  assign want = $signed({{OP_W{a_q[OP_W-1]}}, a_q}) * $signed({{OP_W{b_q[OP_W-1]}}, b_q});

  always_ff @(posedge clk) begin
    if (rst) begin
      edges <= '0;
      a_q   <= '0;
      b_q   <= '0;
    end else if (start && !busy) begin
      edges <= '0;
      a_q   <= mcand;
      b_q   <= mplier;
    end else if (busy && edges <= CW'(ITERS)) begin
      edges <= edges + 1'b1;
    end
  end

  assert_product_R1: assert property (@(posedge clk) disable iff (rst)
    done |-> ($signed({hi, lo}) == want));

  assert_length_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> (edges == CW'(ITERS)));

  assert_fall_done_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  assert_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(hi) && $stable(lo)));

  assert_no_restart_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && edges < CW'(ITERS - 1)) |=> busy);

endmodule

bind booth4_mul booth4_mul_chk #(.OP_W(OP_W)) u_chk (.*);

// File: tb/booth4_mul_test.sv
module booth4_mul_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] mcand = '0;
  logic [31:0] mplier = '0;
  logic        busy;
  logic        done;
  logic [31:0] hi;
  logic [31:0] lo;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  booth4_mul #(.OP_W(32)) uut (
    .clk(clk), .rst(rst), .start(start), .mcand(mcand), .mplier(mplier),
    .busy(busy), .done(done), .hi(hi), .lo(lo)
  );

  function automatic logic [63:0] ref_prod(input logic [31:0] a, input logic [31:0] b);
    logic signed [63:0] sa, sb;
    sa = {{32{a[31]}}, a};
    sb = {{32{b[31]}}, b};
    return sa * sb;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // poke: cycle index at which a stray start with other operands is driven (0 = none)
  task automatic run_mul(input logic [31:0] a, input logic [31:0] b, input string req, input int poke);
    logic [63:0] exp;
    bit seq_ok;
    exp = ref_prod(a, b);
    @(negedge clk);
    mcand = a; mplier = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    mcand = ~a; mplier = b ^ 32'h1357_9bdf;
    seq_ok = busy && !done;
    for (int k = 1; k <= 16; k++) begin
      if (k == poke) begin
        start = 1'b1; mcand = 32'h7fff_ffff; mplier = 32'h8000_0001;
      end
      @(negedge clk);
      start = 1'b0;
      if (k < 16 && !(busy && !done)) seq_ok = 1'b0;
    end
    check(seq_ok && done && !busy, "R2", {62'd0, busy, done}, 64'd1);
    check({hi, lo} == exp, req, {hi, lo}, exp);
    @(negedge clk);
    check(!done && !busy, "R3", {62'd0, busy, done}, 64'd0);
    repeat (3) @(negedge clk);
    check({hi, lo} == exp, "R4", {hi, lo}, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog got=%0d exp=%0d", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R6 reset state
    check(!busy && !done && hi == 0 && lo == 0, "R6", {hi, lo}, 64'd0);

    // R8 corners
    run_mul(32'h8000_0000, 32'h8000_0000, "R8", 0);
    run_mul(32'h8000_0000, 32'hffff_ffff, "R8", 0);
    run_mul(32'hffff_ffff, 32'h8000_0000, "R8", 0);
    run_mul(32'h1234_5678, 32'h0000_0000, "R8", 0);
    run_mul(32'h0000_0000, 32'h8000_0000, "R8", 0);
    run_mul(32'h7fff_ffff, 32'h7fff_ffff, "R8", 0);

    // R7 recoding windows
    run_mul(32'h0bad_cafe, 32'h5555_5555, "R7", 0);
    run_mul(32'h8765_4321, 32'haaaa_aaaa, "R7", 0);
    run_mul(32'h8000_0000, 32'hffff_ffff, "R7", 0);
    run_mul(32'hdead_beef, 32'h3333_3333, "R7", 0);
    run_mul(32'h7fff_fffe, 32'h6666_6666, "R7", 0);
    run_mul(32'hc000_0001, 32'h0000_000c, "R7", 0);

    // R5 stray start mid-run
    run_mul(32'h0000_1234, 32'hffff_fff3, "R5", 5);
    run_mul(32'h8000_0000, 32'h0000_0003, "R5", 16);

    // R1 random
    for (int i = 0; i < 150; i++) begin
      run_mul($urandom, $urandom, "R1", 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule